// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block guesses whether a branch will be taken. For each branch slot it keeps a short shift register of that slot's recent real outcomes. In dynamic mode it predicts taken when most of those outcomes were taken. For comparison it also has two modes that ignore the history. Fixed mode always predicts not taken. Static mode predicts from the branch kind: loop-closing branches are predicted taken and ordinary conditional branches are predicted not taken.

Histories sit in a direct-mapped table indexed by the low bits of the branch address. The lookup port is purely combinational, so a fetch stage can read the prediction in the cycle it presents the address. The resolve port comes from the execute stage. It delivers the real outcome, which is shifted into the addressed history whatever mode is in use. Two saturating counters tally hits and misses. A hit is a resolve whose outcome matches the prediction the block gives for that resolve's own mode and kind, taken from the history as it stood before the update. This lets a bench compare the accuracy of the modes on different outcome patterns.

Top module: `branch_vote_predictor`

## Requirements
- R1: After reset every history entry holds all not-taken outcomes, so dynamic lookups of any index predict not taken, and both counters read zero.
- R2: With mode 2'b00 (fixed), pred_taken is 0 whatever the history or branch kind.
- R3: With mode 2'b01 (static), pred_taken equals lk_loop (1 = loop-closing branch, 0 = ordinary conditional).
- R4: With mode 2'b10 (dynamic), pred_taken is 1 exactly when at least HIST_LEN/2+1 of the HIST_LEN stored outcomes of entry lk_idx are taken (two of three by default).
- R5: Mode 2'b11 is reserved and predicts not taken, as fixed mode does.
- R6: A cycle with rs_valid high shifts rs_taken into entry rs_idx and drops that entry's oldest outcome. No other entry changes.
- R7: A lookup reflects the table in the same cycle. A resolve takes effect from the next cycle, so a lookup of the entry being resolved in that same cycle still sees the old history.
- R8: The history update takes place in every mode, including fixed and static.
- R9: On each resolve, exactly one of hit_count and miss_count rises by one. It is hit_count when rs_taken equals the prediction for rs_mode, rs_loop and the pre-update history of rs_idx, and miss_count otherwise.
- R10: Each counter saturates at all ones and holds there.
- R11: In a cycle with rs_valid low, no history entry and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_idx | input | IDX_W | Low address bits of the branch being looked up |
| lk_loop | input | 1 | Kind of the looked-up branch, 1 = loop-closing |
| mode | input | 2 | Prediction mode for the lookup: 00 fixed, 01 static, 10 dynamic, 11 reserved |
| pred_taken | output | 1 | Combinational prediction, 1 = taken |
| rs_valid | input | 1 | Resolve pulse, one outcome per cycle |
| rs_idx | input | IDX_W | Low address bits of the resolved branch |
| rs_loop | input | 1 | Kind of the resolved branch |
| rs_mode | input | 2 | Mode under which the resolved branch was predicted |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| hit_count | output | CNT_W | Saturating count of correct predictions |
| miss_count | output | CNT_W | Saturating count of wrong predictions |

## Verification
The bench builds the block with IDX_W = 4 and HIST_LEN = 3, the defaults, so all sixteen entries and the two-of-three vote are exercised as specified. CNT_W is set to 8, so both counters reach their all-ones limit within a few thousand random resolves and the saturation rule can be observed. Random index traffic is drawn over the full table, often with the lookup and resolve pointed at the same entry. This covers aliasing between slots and same-cycle collisions of a lookup and an update, alongside a directed loop-shaped outcome train.

// File: rtl/branch_vote_predictor.sv
module branch_vote_predictor #(
  parameter int IDX_W    = 4,
  parameter int HIST_LEN = 3,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             lk_loop,
  input  logic [1:0]       mode,
  output logic             pred_taken,
  input  logic             rs_valid,
  input  logic [IDX_W-1:0] rs_idx,
  input  logic             rs_loop,
  input  logic [1:0]       rs_mode,
  input  logic             rs_taken,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int VOTE    = HIST_LEN / 2 + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [HIST_LEN-1:0] hist [ENTRIES];

  function automatic logic majority(input logic [HIST_LEN-1:0] h);
    int n;
    n = 0;
    for (int i = 0; i < HIST_LEN; i++) n += int'(h[i]);
    return n >= VOTE;
  endfunction

  function automatic logic predict(input logic [1:0] m, input logic loop_k,
                                   input logic [HIST_LEN-1:0] h);
    case (m)
      2'b01:   return loop_k;
      2'b10:   return majority(h);
      default: return 1'b0;
    endcase
  endfunction

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          hist[e] <= '0;
        else if (rs_valid && rs_idx == IDX_W'(e))
          hist[e] <= {hist[e][HIST_LEN-2:0], rs_taken};
      end
    end
  endgenerate

  logic rs_pred, rs_hit;
  assign pred_taken = predict(mode, lk_loop, hist[lk_idx]);
  assign rs_pred    = predict(rs_mode, rs_loop, hist[rs_idx]);
  assign rs_hit     = rs_pred == rs_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (rs_valid) begin
      if (rs_hit && hit_count != CNT_MAX)    hit_count  <= hit_count + 1'b1;
      if (!rs_hit && miss_count != CNT_MAX)  miss_count <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/vote_pred_chk.sv
module vote_pred_chk #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] lk_idx,
  input logic             lk_loop,
  input logic [1:0]       mode,
  input logic             pred_taken,
  input logic             rs_valid,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W:0] tally;
  assign tally = {1'b0, hit_count} + {1'b0, miss_count};

  // R2
  fixed_never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !pred_taken);
  // R5
  reserved_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !pred_taken);
  // R3
  static_follows_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (pred_taken == lk_loop));
  // R9
  one_tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && hit_count != CNT_MAX && miss_count != CNT_MAX)
      |=> (tally == $past(tally) + 1'b1));
  // R11
  idle_counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> ($stable(hit_count) && $stable(miss_count)));
  // R10
  hit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count == CNT_MAX) |=> (hit_count == CNT_MAX));
  // R10
  miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == CNT_MAX) |=> (miss_count == CNT_MAX));
  // R1
  idx_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pred_taken));
endmodule

bind branch_vote_predictor vote_pred_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_loop(lk_loop), .mode(mode),
  .pred_taken(pred_taken), .rs_valid(rs_valid), .hit_count(hit_count),
  .miss_count(miss_count)
);

// File: tb/branch_vote_predictor_tb_top.sv
`timescale 1ns/1ps
module branch_vote_predictor_tb_top;
  localparam int IDX_W = 4;
  localparam int HL    = 3;
  localparam int CW    = 8;
  localparam int ENT   = 1 << IDX_W;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IDX_W-1:0] lk_idx = '0, rs_idx = '0;
  logic lk_loop = 1'b0, rs_valid = 1'b0, rs_loop = 1'b0, rs_taken = 1'b0;
  logic [1:0] mode = 2'b00, rs_mode = 2'b00;
  logic pred_taken;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0, fails = 0;
  logic [HL-1:0] m_hist [ENT];
  int m_hit = 0, m_miss = 0;

  always #2.5 clk = ~clk;

  branch_vote_predictor #(.IDX_W(IDX_W), .HIST_LEN(HL), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_loop(lk_loop), .mode(mode),
    .pred_taken(pred_taken), .rs_valid(rs_valid), .rs_idx(rs_idx),
    .rs_loop(rs_loop), .rs_mode(rs_mode), .rs_taken(rs_taken),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic logic ref_pred(input logic [1:0] m, input logic k,
                                    input logic [HL-1:0] h);
    int n;
    n = 0;
    for (int i = 0; i < HL; i++) n += int'(h[i]);
    if (m == 2'b01) return k;
    if (m == 2'b10) return n >= (HL / 2 + 1);
    return 1'b0;
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [IDX_W-1:0] li, input logic lk, input logic [1:0] lm,
                      input logic rv, input logic [IDX_W-1:0] ri, input logic rk,
                      input logic [1:0] rm, input logic rt, input string tag);
    logic rp;
    @(negedge clk);
    lk_idx = li; lk_loop = lk; mode = lm;
    rs_valid = rv; rs_idx = ri; rs_loop = rk; rs_mode = rm; rs_taken = rt;
    #1;
    check({mode_req(lm), tag}, int'(pred_taken), int'(ref_pred(lm, lk, m_hist[li])));
    check("R9 hit", int'(hit_count), m_hit);
    check("R10 miss", int'(miss_count), m_miss);
    if (rv) begin
      rp = ref_pred(rm, rk, m_hist[ri]);
      if (rp == rt) begin if (m_hit < CMAX) m_hit++; end
      else begin if (m_miss < CMAX) m_miss++; end
      m_hist[ri] = {m_hist[ri][HL-2:0], rt};
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    for (int i = 0; i < ENT; i++) m_hist[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every entry predicts not taken in dynamic mode, counters zero
    for (int i = 0; i < ENT; i++) begin
      @(negedge clk);
      lk_idx = IDX_W'(i); mode = 2'b10; lk_loop = 1'b1; rs_valid = 1'b0;
      #1;
      check("R1 pred", int'(pred_taken), 0);
    end
    check("R1 hit", int'(hit_count), 0);
    check("R1 miss", int'(miss_count), 0);

    // R8: train entry 3 while in fixed mode, then read it in dynamic mode
    step(4'd3, 1'b0, 2'b00, 1'b1, 4'd3, 1'b0, 2'b00, 1'b1, " R8");
    step(4'd3, 1'b0, 2'b00, 1'b1, 4'd3, 1'b0, 2'b01, 1'b1, " R8");
    step(4'd3, 1'b0, 2'b10, 1'b0, 4'd0, 1'b0, 2'b00, 1'b0, " R8");
    check("R8 trained", int'(pred_taken), 1);
    // R6: neighbour untouched
    step(4'd4, 1'b0, 2'b10, 1'b0, 4'd0, 1'b0, 2'b00, 1'b0, " R6");
    check("R6 other entry", int'(pred_taken), 0);
    // R7: same-cycle resolve of not taken still shows old value
    step(4'd3, 1'b0, 2'b10, 1'b1, 4'd3, 1'b0, 2'b10, 1'b0, " R7");
    check("R7 old value", int'(pred_taken), 1);
    step(4'd3, 1'b0, 2'b10, 1'b1, 4'd3, 1'b0, 2'b10, 1'b0, " R7");
    check("R7 after one", int'(pred_taken), 1);
    step(4'd3, 1'b0, 2'b10, 1'b0, 4'd0, 1'b0, 2'b10, 1'b0, " R6");
    check("R6 oldest dropped", int'(pred_taken), 0);

    // loop-shaped train on entry 7 (taken, taken, taken, not taken)
    for (int i = 0; i < 40; i++)
      step(4'd7, 1'b1, 2'b10, 1'b1, 4'd7, 1'b1, 2'b10, (i % 4) != 3, " loop");

    // R11: idle cycles with varied lookups leave state alone
    for (int i = 0; i < 50; i++)
      step(IDX_W'($urandom_range(0, ENT - 1)), 1'($urandom), 2'($urandom),
           1'b0, 4'd0, 1'b0, 2'b00, 1'b0, " R11");

    // random traffic with frequent index collisions
    for (int i = 0; i < 4000; i++) begin
      logic [IDX_W-1:0] li, ri;
      li = IDX_W'($urandom_range(0, ENT - 1));
      ri = ($urandom_range(0, 9) < 3) ? li : IDX_W'($urandom_range(0, ENT - 1));
      step(li, 1'($urandom), 2'($urandom), $urandom_range(0, 3) != 0, ri,
           1'($urandom), 2'($urandom), $urandom_range(0, 9) < 6, " rand");
    end

    step(4'd0, 1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 2'b00, 1'b0, " end");
    check("R10 hit saturated", int'(hit_count), CMAX);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule